// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Software writes into a single-entry holding register whenever the empty flag is high. On a baud tick, if the line is free and transmission is enabled, the held byte moves into a shift register. The empty flag rises again on that same clock edge, so the next byte can be queued while the current frame is still on the line. The line idles high.

Two frame layouts are supported. In normal mode the frame carries 7 or 8 data bits with an optional even or odd parity bit. In multiprocessor mode it carries 8 data bits followed by an address/data flag bit, and it never carries parity. The frame format is taken from the configuration inputs at the moment a byte is loaded. A single baud tick pulse from outside sets the timing of every bit. A level interrupt tells software when the holding register can take another byte.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset `txd_o` is 1 and `empty_o` is 1, and `irq_o` follows `tie_i`.
- R2: A cycle with `wr_i`=1 while `empty_o`=1 stores `wr_data_i`, and `empty_o` reads 0 from the next cycle.
- R3: A write while `empty_o`=0 is ignored: the byte already held is the one transmitted.
- R4: On a clock edge with `baud_tick_i`=1, a held byte is loaded if the line is free and `tx_en_i`=1. On that same edge `txd_o` goes to the start bit (0) and `empty_o` returns to 1.
- R5: A frame is a start bit of 0, then the data bits least significant bit first, then a stop bit of 1. Each bit lasts from one baud tick to the next, and `txd_o` changes only on clock edges with `baud_tick_i`=1. For example, 0x4D in normal 8-bit mode without parity produces the line sequence 0,1,0,1,1,0,0,1,0,1.
- R6: In normal mode with `len8_i`=0, only data bits 0..6 are sent and bit 7 of the byte has no effect on the line.
- R7: In normal mode with `par_en_i`=1, a parity bit follows the data bits. With `par_odd_i`=0 the number of ones in data plus parity is even; with `par_odd_i`=1 it is odd.
- R8: With `mp_mode_i`=1 the frame carries 8 data bits followed by the value of `adr_bit_i`, then the stop bit. `len8_i` and `par_en_i` are ignored in this mode.
- R9: A byte queued during a frame sends its start bit on the baud tick that ends the previous stop bit, with no idle bit between the two frames.
- R10: While `tx_en_i`=0 no byte is loaded. A frame already in progress still finishes, and the line then stays at 1.
- R11: `irq_o` is 1 exactly when `empty_o`=1 and `tie_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| tx_en_i | input | 1 | Transmit enable |
| tie_i | input | 1 | Transmit interrupt enable |
| mp_mode_i | input | 1 | 1 selects multiprocessor frame layout |
| len8_i | input | 1 | Normal mode: 1 selects 8 data bits, 0 selects 7 |
| par_en_i | input | 1 | Normal mode: adds a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| adr_bit_i | input | 1 | Address/data flag value for multiprocessor frames |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| txd_o | output | 1 | Serial output, idle high |
| empty_o | output | 1 | Holding register can take a byte |
| irq_o | output | 1 | Transmit interrupt |

## Verification
The bench goes after the edge where a load and a stop-bit end fall on the same tick. If the design raised the empty flag at the end of the frame, or inserted an idle bit before the queued frame, the line sequence would slip against the expected one. It writes into a full holding register; a design that overwrote the register would send the second byte. It sets bit 7 in 7-bit mode and switches parity sense and the multiprocessor flag; a design that got these wrong would send a wrong bit count or a wrong parity or flag bit. It also drops the enable in the middle of a frame: a design that cut the frame short would send a truncated frame, and one that kept loading would start a frame that should not be sent.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic mp;
    logic len8;
    logic par_en;
    logic par_odd;
    logic adr;
  } tx_cfg_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] hold_q;
  logic              empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_i && empty_q) begin
      hold_q  <= data_i;
      empty_q <= 1'b0;
    end else if (load_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o  = hold_q;
  assign empty_o = empty_q;

  // R3
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !empty_q) |=> $stable(hold_q));
  // R2
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && empty_q) |=> !empty_q);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = 4
) (
  input  logic [DATA_W-1:0]  data_i,
  input  tx_cfg_t            cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  logic [CNT_W-1:0] n_data;
  logic             has_extra;
  logic             extra_bit;
  logic             par_acc;

  always_comb begin
    n_data    = (cfg_i.mp || cfg_i.len8) ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    has_extra = cfg_i.mp || cfg_i.par_en;
    par_acc   = 1'b0;
    frame_o   = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < n_data) begin
        frame_o[1+i] = data_i[i];
        par_acc      = par_acc ^ data_i[i];
      end
    end
    extra_bit = cfg_i.mp ? cfg_i.adr : (par_acc ^ cfg_i.par_odd);
    for (int j = 1; j < FRAME_W; j++) begin
      if (has_extra && (CNT_W'(j) == n_data + CNT_W'(1))) frame_o[j] = extra_bit;
    end
    nbits_o = n_data + CNT_W'(2) + CNT_W'(has_extra);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic               full_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  output logic               load_o,
  output logic               txd_o
);
  logic [FRAME_W-2:0] sreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               txd_q;
  logic               line_free;

  // free when idle or while the stop bit is on the line
  assign line_free = !busy_q || (cnt_q == '0);
  assign load_o    = tick_i && line_free && en_i && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load_o) begin
      txd_q  <= frame_i[0];
      sreg_q <= frame_i[FRAME_W-1:1];
      cnt_q  <= nbits_i - CNT_W'(1);
      busy_q <= 1'b1;
    end else if (tick_i) begin
      if (line_free) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else begin
        txd_q  <= sreg_q[0];
        sreg_q <= {1'b1, sreg_q[FRAME_W-2:1]};
        cnt_q  <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign txd_o = txd_q;

  // R10
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q) |-> txd_q);
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              tie_i,
  input  logic              mp_mode_i,
  input  logic              len8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              adr_bit_i,
  input  logic              baud_tick_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              irq_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  tx_cfg_t             cfg;
  logic [DATA_W-1:0]   hold_data;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    nbits;
  logic                load;

  assign cfg = '{mp: mp_mode_i, len8: len8_i, par_en: par_en_i,
                 par_odd: par_odd_i, adr: adr_bit_i};

  uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .data_i  (wr_data_i),
    .load_i  (load),
    .data_o  (hold_data),
    .empty_o (empty_o)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_frame (
    .data_i  (hold_data),
    .cfg_i   (cfg),
    .frame_o (frame),
    .nbits_o (nbits)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .en_i    (tx_en_i),
    .full_i  (!empty_o),
    .frame_i (frame),
    .nbits_i (nbits),
    .load_o  (load),
    .txd_o   (txd_o)
  );

  assign irq_o = empty_o && tie_i;

  // R4
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> ($past(baud_tick_i) && $past(tx_en_i) && !txd_o));
  // R5
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(txd_o));
  // R10
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !empty_o) |=> !empty_o || $past(wr_i));
endmodule

// File: tb/test_uart_tx_buf.sv
module test_uart_tx_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       tx_en_i = 1'b1;
  logic       tie_i = 1'b1;
  logic       mp_mode_i = 1'b0;
  logic       len8_i = 1'b1;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       adr_bit_i = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       txd_o, empty_o, irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R5";

  // reference state
  logic        m_empty = 1'b1;
  logic [7:0]  m_hold = '0;
  logic        m_busy = 1'b0;
  logic        m_txd = 1'b1;
  logic [10:0] m_sreg = '1;
  int          m_left = 0;

  always #5 clk_i = ~clk_i;

  uart_tx_buf i_uart_tx_buf (
    .clk_i, .rst_ni, .wr_i, .wr_data_i, .tx_en_i, .tie_i, .mp_mode_i,
    .len8_i, .par_en_i, .par_odd_i, .adr_bit_i, .baud_tick_i,
    .txd_o, .empty_o, .irq_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // frame built from the requirements: start, data LSB first, optional bit, stop
  function automatic void mk_frame(input logic [7:0] d, output logic [10:0] f, output int n);
    int nd = (mp_mode_i || len8_i) ? 8 : 7;
    int idx;
    int ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      ones += int'(d[i]);
    end
    idx = 1 + nd;
    if (mp_mode_i) begin f[idx] = adr_bit_i; idx++; end
    else if (par_en_i) begin f[idx] = logic'(ones % 2) ^ par_odd_i; idx++; end
    f[idx] = 1'b1;
    n = idx + 1;
  endfunction

  task automatic cycle(input bit wr, input logic [7:0] d, input bit tk);
    logic [10:0] f;
    int n;
    bit load = 0;
    wr_i = wr; wr_data_i = d; baud_tick_i = tk;
    @(posedge clk_i);
    if (tk) begin
      if (!m_busy || m_left == 0) begin
        if (!m_empty && tx_en_i) begin
          load = 1;
          mk_frame(m_hold, f, n);
          m_txd = f[0]; m_sreg = {1'b1, f[10:1]}; m_left = n - 1; m_busy = 1;
        end else begin
          m_busy = 0; m_txd = 1'b1;
        end
      end else begin
        m_txd = m_sreg[0]; m_sreg = {1'b1, m_sreg[10:1]}; m_left--;
      end
    end
    if (wr && m_empty) begin m_hold = d; m_empty = 0; end
    else if (load) m_empty = 1;
    @(negedge clk_i);
    wr_i = 0; baud_tick_i = 0;
    chk(cur_tag, txd_o, m_txd);
    chk((cur_tag == "R3") ? "R3" : "R2/R4", empty_o, m_empty);
    chk("R11", irq_o, m_empty & tie_i);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      cycle(0, 8'h00, 1);
      for (int g = 0; g < gap; g++) cycle(0, 8'h00, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1", txd_o, 1'b1);
    chk("R1", empty_o, 1'b1);
    chk("R1", irq_o, 1'b1);
    tie_i = 0; #1; chk("R1", irq_o, 1'b0); tie_i = 1;

    // R5: explicit sequence of 0x4D
    cur_tag = "R5";
    cycle(1, 8'h4D, 0);
    seen = '0;
    for (int b = 0; b < 10; b++) begin
      cycle(0, 8'h00, 1);
      seen[b] = txd_o;
      cycle(0, 8'h00, 0);
    end
    chk("R5", seen, 10'h29A);
    ticks(2, 1);

    // R3: write while full is dropped
    cur_tag = "R3";
    cycle(1, 8'hA5, 0);
    cycle(1, 8'h3C, 0);
    chk("R3", empty_o, 1'b0);
    ticks(13, 2);

    // R6: bit 7 must not appear, with parity both senses (R7)
    cur_tag = "R6";
    len8_i = 0;
    cycle(1, 8'hFF, 0); ticks(12, 1);
    cur_tag = "R7";
    par_en_i = 1; par_odd_i = 0;
    cycle(1, 8'h83, 0); ticks(12, 1);
    len8_i = 1; par_odd_i = 1;
    cycle(1, 8'h5B, 0); ticks(13, 1);

    // R8: multiprocessor flag 1 then 0, config bits that must be ignored
    cur_tag = "R8";
    mp_mode_i = 1; len8_i = 0; par_en_i = 1; adr_bit_i = 1;
    cycle(1, 8'hC3, 0); ticks(13, 1);
    adr_bit_i = 0;
    cycle(1, 8'h81, 0); ticks(13, 1);
    mp_mode_i = 0; len8_i = 1; par_en_i = 0;

    // R9: queue during a frame, no gap between frames
    cur_tag = "R9";
    cycle(1, 8'h11, 0);
    cycle(0, 8'h00, 1);
    chk("R9", empty_o, 1'b1);
    cycle(1, 8'hEE, 0);
    ticks(9, 1);
    cycle(0, 8'h00, 1);
    chk("R9", txd_o, 1'b0);
    ticks(12, 1);

    // R10: enable drop mid frame
    cur_tag = "R10";
    cycle(1, 8'h0F, 0);
    ticks(3, 1);
    tx_en_i = 0;
    cycle(1, 8'h77, 0);
    ticks(15, 1);
    chk("R10", txd_o, 1'b1);
    chk("R10", empty_o, 1'b0);
    tx_en_i = 1;
    ticks(14, 1);

    // constrained random
    cur_tag = "R4";
    for (int it = 0; it < 20000; it++) begin
      bit wr, tk;
      if ($urandom_range(0, 199) == 0) begin
        mp_mode_i = 1'($urandom); len8_i = 1'($urandom); par_en_i = 1'($urandom);
        par_odd_i = 1'($urandom); adr_bit_i = 1'($urandom);
      end
      if ($urandom_range(0, 299) == 0) tx_en_i = ~tx_en_i;
      if ($urandom_range(0, 99) == 0) tie_i = 1'($urandom);
      wr = ($urandom_range(0, 9) == 0);
      tk = ($urandom_range(0, 3) == 0);
      cycle(wr, 8'($urandom), tk);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1517));
  end
endmodule